// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Responder

This block is a synthesizable model of the device end of a three-wire serial EEPROM holding 64 words of 16 bits. A bus master drives chip select, a serial clock and a data line into it. The block answers on a single data-out pin. It keeps its words in an internal register array, which stands in for the non-volatile cells. It exists so that a serial EEPROM master controller can be checked against a partner that behaves like a real part at the frame level: start bit, opcode, address, data, the dummy zero and the busy/ready status after programming.

All three inputs are brought into the system clock domain through a configurable synchronizer. Serial clock rising edges are then detected on the system clock, so the serial clock must run several times slower than the system clock. Programming time is modelled as a fixed number of system clock cycles. Analog timing and retention over power loss are not modelled.

Top module: `mwe_responder`

## Requirements
- R1: After reset, `dout` is 1, `dout_oe` is 0, every stored word reads 16'hFFFF and programming is locked.
- R2: While the synchronized chip select is low, `dout` is held at 1 and `dout_oe` at 0, whatever the previous frame drove.
- R3: A frame begins only on a serial clock rising edge that samples `di` = 1 while chip select is high. Then follow a 2-bit opcode and a 6-bit word address, each sent MSB first on rising edges. The opcode values are 2'b10 read, 2'b01 write, 2'b11 erase and 2'b00 extended.
- R4: For a read, `dout` goes to 0 after the last address bit (the dummy zero). The 16 bits of the addressed word then appear MSB first, one per following rising edge.
- R5: For a write, 16 data bits are taken MSB first after the address. The word is stored when chip select falls after all 16 bits have arrived.
- R6: An accepted erase sets the addressed word to 16'hFFFF when chip select falls.
- R7: In an extended frame, address bits [5:4] = 2'b11 unlock programming and 2'b00 lock it. The values 2'b01 and 2'b10 change nothing.
- R8: While programming is locked, write and erase frames leave the stored words unchanged, and no busy period follows them.
- R9: After an accepted write or erase, `dout` reads 0 whenever chip select is high during the next BUSY_CYCLES system clock cycles. After that it reads 1.
- R10: While busy, start bits are ignored, so no frame sent during programming has any effect.
- R11: If chip select drops before a write frame is complete, no stored word changes and no busy period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select from the master, active high |
| sk | input | 1 | Serial clock from the master |
| di | input | 1 | Serial data from the master |
| dout | output | 1 | Serial data to the master, 1 when idle |
| dout_oe | output | 1 | High while the responder is selected and owns `dout` |

## Verification
The bench builds the block with the default 6-bit address, 16-bit words and a two-stage synchronizer. BUSY_CYCLES is set to 600, so that a full 25-bit frame, sent with 18 system clocks per serial bit, fits inside one busy window. That makes it possible to send a complete write frame while programming is still in progress and to confirm that it is discarded. The short window also keeps busy polling to a few hundred cycles. Every address bit, including address 63 and address 0, is reachable through the table.

// File: rtl/mwe_pkg.sv
package mwe_pkg;

   // Opcode field values, sent MSB first after the start bit
   typedef enum logic [1:0] {
      OP_EXT   = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_ERASE = 2'b11
   } mwe_op_e;

   // Frame phases of the serial front end
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_OPC   = 3'd1,
      PH_ADDR  = 3'd2,
      PH_RDATA = 3'd3,
      PH_WDATA = 3'd4,
      PH_DONE  = 3'd5
   } mwe_phase_e;

   // Extended-group selector carried in the top two address bits
   localparam logic [1:0] EXT_UNLOCK = 2'b11;
   localparam logic [1:0] EXT_LOCK   = 2'b00;

endpackage

// File: rtl/mwe_sync.sv
module mwe_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/mwe_frame.sv
module mwe_frame
   import mwe_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              sk_rise,
   input  logic              di,
   input  logic              busy,
   input  logic [DATA_W-1:0] rd_word,
   output logic [ADDR_W-1:0] addr_q,
   output mwe_phase_e        phase_q,
   output logic              drv_q,
   output logic              bit_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              commit_o,
   output logic              commit_erase_o,
   output logic              ext_en_o,
   output logic              ext_dis_o
);

   localparam int CNT_MAX = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
   localparam int CNT_W   = $clog2(CNT_MAX) + 1;

   logic [1:0]        op_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] sh_q;
   logic              cs_q;
   logic              arm_wr_q;
   logic              arm_er_q;
   logic [ADDR_W-1:0] addr_nxt;
   logic [1:0]        ext_sel;

   assign addr_nxt = {addr_q[ADDR_W-2:0], di};
   assign ext_sel  = addr_nxt[ADDR_W-1 -: 2];
   assign wdata_q  = sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q        <= PH_IDLE;
         op_q           <= 2'b00;
         addr_q         <= '0;
         sh_q           <= '0;
         cnt_q          <= '0;
         drv_q          <= 1'b0;
         bit_q          <= 1'b1;
         cs_q           <= 1'b0;
         arm_wr_q       <= 1'b0;
         arm_er_q       <= 1'b0;
         commit_o       <= 1'b0;
         commit_erase_o <= 1'b0;
         ext_en_o       <= 1'b0;
         ext_dis_o      <= 1'b0;
      end else begin
         commit_o       <= 1'b0;
         commit_erase_o <= 1'b0;
         ext_en_o       <= 1'b0;
         ext_dis_o      <= 1'b0;
         cs_q           <= cs;
         if (!cs) begin
            // deselect: finish a complete command, abort anything partial
            if (cs_q) begin
               commit_o       <= arm_wr_q | arm_er_q;
               commit_erase_o <= arm_er_q;
            end
            phase_q  <= PH_IDLE;
            drv_q    <= 1'b0;
            arm_wr_q <= 1'b0;
            arm_er_q <= 1'b0;
            cnt_q    <= '0;
         end else if (sk_rise) begin
            case (phase_q)
               PH_IDLE: begin
                  if (di && !busy) begin
                     phase_q <= PH_OPC;
                     cnt_q   <= '0;
                  end
               end
               PH_OPC: begin
                  op_q <= {op_q[0], di};
                  if (cnt_q == CNT_W'(1)) begin
                     phase_q <= PH_ADDR;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               PH_ADDR: begin
                  addr_q <= addr_nxt;
                  if (cnt_q == CNT_W'(ADDR_W - 1)) begin
                     cnt_q <= '0;
                     case (mwe_op_e'(op_q))
                        OP_READ: begin
                           phase_q <= PH_RDATA;
                           drv_q   <= 1'b1;
                           bit_q   <= 1'b0;
                        end
                        OP_WRITE: phase_q <= PH_WDATA;
                        OP_ERASE: begin
                           phase_q  <= PH_DONE;
                           arm_er_q <= 1'b1;
                        end
                        default: begin
                           phase_q   <= PH_DONE;
                           ext_en_o  <= (ext_sel == EXT_UNLOCK);
                           ext_dis_o <= (ext_sel == EXT_LOCK);
                        end
                     endcase
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               PH_RDATA: begin
                  if (cnt_q == '0) begin
                     bit_q <= rd_word[DATA_W-1];
                     sh_q  <= {rd_word[DATA_W-2:0], 1'b0};
                  end else begin
                     bit_q <= sh_q[DATA_W-1];
                     sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
                  end
                  if (cnt_q == CNT_W'(DATA_W - 1)) phase_q <= PH_DONE;
                  else cnt_q <= cnt_q + 1'b1;
               end
               PH_WDATA: begin
                  sh_q <= {sh_q[DATA_W-2:0], di};
                  if (cnt_q == CNT_W'(DATA_W - 1)) begin
                     phase_q  <= PH_DONE;
                     arm_wr_q <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/mwe_store.sv
module mwe_store #(
   parameter int          ADDR_W      = 6,
   parameter int          DATA_W      = 16,
   parameter int          BUSY_CYCLES = 1000,
   parameter logic [15:0] FILL        = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              commit,
   input  logic              commit_erase,
   input  logic              ext_en,
   input  logic              ext_dis,
   output logic [DATA_W-1:0] rd_word,
   output logic              busy,
   output logic              wen
);

   localparam int DEPTH  = 1 << ADDR_W;
   localparam int BCNT_W = $clog2(BUSY_CYCLES + 1);

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [BCNT_W-1:0] bcnt_q;

   assign rd_word = mem_q[addr];
   assign busy    = (bcnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= DATA_W'(FILL);
         bcnt_q <= '0;
         wen    <= 1'b0;
      end else begin
         if (ext_en)       wen <= 1'b1;
         else if (ext_dis) wen <= 1'b0;
         if (commit && wen && !busy) begin
            mem_q[addr] <= commit_erase ? '1 : wdata;
            bcnt_q      <= BCNT_W'(BUSY_CYCLES);
         end else if (busy) begin
            bcnt_q <= bcnt_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/mwe_responder.sv
module mwe_responder
   import mwe_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 16,
   parameter int BUSY_CYCLES = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sk,
   input  logic di,
   output logic dout,
   output logic dout_oe
);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (DATA_W < 2 || DATA_W > 16) begin : g_bad_data
         $error("DATA_W must lie in 2..16");
      end
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("BUSY_CYCLES must be at least 1");
      end
   endgenerate

   logic [2:0]        pins_s;
   logic              cs_s, sk_s, di_s, sk_q, sk_rise;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] rd_word, wdata;
   mwe_phase_e        phase;
   logic              drv, dbit, commit, commit_erase, ext_en, ext_dis;
   logic              busy, wen;

   mwe_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs, sk, di}), .q(pins_s));

   assign {cs_s, sk_s, di_s} = pins_s;
   assign sk_rise = sk_s & ~sk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sk_q <= 1'b0;
      else        sk_q <= sk_s;
   end

   mwe_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .cs(cs_s), .sk_rise(sk_rise), .di(di_s),
      .busy(busy), .rd_word(rd_word), .addr_q(addr_q), .phase_q(phase),
      .drv_q(drv), .bit_q(dbit), .wdata_q(wdata), .commit_o(commit),
      .commit_erase_o(commit_erase), .ext_en_o(ext_en), .ext_dis_o(ext_dis));

   mwe_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
      .clk(clk), .rst_n(rst_n), .addr(addr_q), .wdata(wdata), .commit(commit),
      .commit_erase(commit_erase), .ext_en(ext_en), .ext_dis(ext_dis),
      .rd_word(rd_word), .busy(busy), .wen(wen));

   // registered pin driver: idle high, frame data while reading, else status
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout    <= 1'b1;
         dout_oe <= 1'b0;
      end else begin
         dout_oe <= cs_s;
         if (!cs_s)    dout <= 1'b1;
         else if (drv) dout <= dbit;
         else          dout <= ~busy;
      end
   end

endmodule

// File: rtl/mwe_checker.sv
module mwe_checker
   import mwe_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cs_s,
   input logic       dout,
   input logic       dout_oe,
   input logic       busy,
   input logic       wen,
   input logic       commit,
   input logic       ext_en,
   input logic       ext_dis,
   input mwe_phase_e phase
);

   p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> (dout && !dout_oe));

   p_dummy_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && phase == PH_RDATA && $past(phase) == PH_ADDR) |=> !dout);

   p_unlock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ext_en |=> wen);

   p_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ext_dis |=> !wen);

   p_locked_no_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !wen && !busy) |=> !busy);

   p_busy_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(commit && wen));

   p_busy_shows_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cs_s && phase == PH_IDLE) |=> !dout);

   p_no_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && busy) |=> phase == PH_IDLE);

endmodule

bind mwe_responder mwe_checker u_chk (
   .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .dout(dout), .dout_oe(dout_oe),
   .busy(busy), .wen(wen), .commit(commit), .ext_en(ext_en),
   .ext_dis(ext_dis), .phase(phase));

// File: tb/mwe_responder_bench.sv
module mwe_responder_bench;

   localparam int BUSY = 600;

   typedef struct packed {
      logic [2:0]  kind;
      logic [5:0]  addr;
      logic [15:0] data;
      logic [15:0] expv;
      logic        exp_busy;
   } vec_t;

   localparam logic [2:0] K_EN = 3'd0, K_DIS = 3'd1, K_WR = 3'd2, K_ER = 3'd3, K_RD = 3'd4;
   localparam int NV = 11;
   localparam vec_t TBL [NV] = '{
      '{K_EN,  6'd0,  16'h0000, 16'h0000, 1'b0},
      '{K_WR,  6'd5,  16'hA5C3, 16'h0000, 1'b1},
      '{K_RD,  6'd5,  16'h0000, 16'hA5C3, 1'b0},
      '{K_WR,  6'd63, 16'h1234, 16'h0000, 1'b1},
      '{K_RD,  6'd63, 16'h0000, 16'h1234, 1'b0},
      '{K_ER,  6'd5,  16'h0000, 16'h0000, 1'b1},
      '{K_RD,  6'd5,  16'h0000, 16'hFFFF, 1'b0},
      '{K_DIS, 6'd0,  16'h0000, 16'h0000, 1'b0},
      '{K_WR,  6'd63, 16'h0000, 16'h0000, 1'b0},
      '{K_RD,  6'd63, 16'h0000, 16'h1234, 1'b0},
      '{K_RD,  6'd0,  16'h0000, 16'hFFFF, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, sk = 1'b0, di = 1'b0;
   logic dout, dout_oe;
   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;

   always #4 clk = ~clk;

   mwe_responder #(.ADDR_W(6), .DATA_W(16), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u_mwe_responder (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .dout(dout), .dout_oe(dout_oe));

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clk_bit(input logic b, output logic hi, output logic lo);
      di = b;  waitc(6);
      sk = 1'b1; waitc(6); hi = dout;
      sk = 1'b0; waitc(6); lo = dout;
   endtask

   // start bit, opcode, address, then nbits data clocks
   task automatic frame(input logic [1:0] op, input logic [5:0] a, input int nbits,
                        input logic [15:0] wd, output logic [15:0] rd, output logic dummy);
      logic h, l;
      rd = 16'hFFFF;
      cs = 1'b1; waitc(6);
      clk_bit(1'b1, h, l);
      clk_bit(op[1], h, l);
      clk_bit(op[0], h, l);
      for (int i = 5; i >= 0; i--) clk_bit(a[i], h, l);
      dummy = l;
      for (int i = 0; i < nbits; i++) begin
         clk_bit(wd[15-i], h, l);
         rd[15-i] = h;
      end
   endtask

   task automatic deselect();
      cs = 1'b0; di = 1'b0; waitc(8);
   endtask

   task automatic poll(output logic s1, output logic s2);
      cs = 1'b0; waitc(4);
      cs = 1'b1; waitc(8); s1 = dout;
      waitc(BUSY + 40);   s2 = dout;
      deselect();
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R1..R11 run actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] rd;
      logic dm, s1, s2;
      waitc(5);
      // R1: reset state at the pins
      check("R1 dout after reset", {15'd0, dout}, 16'd1);
      check("R1 dout_oe after reset", {15'd0, dout_oe}, 16'd0);
      rst_n = 1'b1; waitc(5);

      // R1: locked at reset -> write to 20 is refused (R8)
      frame(2'b01, 6'd20, 16, 16'h0001, rd, dm);
      poll(s1, s2);
      check("R8 no busy when locked after reset", {15'd0, s1}, 16'd1);
      frame(2'b10, 6'd20, 16, 16'h0, rd, dm);
      deselect();
      check("R1 locked at reset, word stays FFFF", rd, 16'hFFFF);

      for (int v = 0; v < NV; v++) begin
         case (TBL[v].kind)
            K_EN:  begin frame(2'b00, 6'b110000, 0, 16'h0, rd, dm); deselect(); end
            K_DIS: begin frame(2'b00, 6'b000000, 0, 16'h0, rd, dm); deselect(); end
            K_WR, K_ER: begin
               frame((TBL[v].kind == K_WR) ? 2'b01 : 2'b11, TBL[v].addr,
                     (TBL[v].kind == K_WR) ? 16 : 0, TBL[v].data, rd, dm);
               poll(s1, s2);
               check("R9/R8 status right after program", {15'd0, s1}, {15'd0, ~TBL[v].exp_busy});
               check("R9 ready after busy window", {15'd0, s2}, 16'd1);
            end
            default: begin
               frame(2'b10, TBL[v].addr, 16, 16'h0, rd, dm);
               check("R4 dummy zero after address", {15'd0, dm}, 16'd0);
               check("R3/R5/R6 read data", rd, TBL[v].expv);
               deselect();
               check("R2 dout high after deselect", {14'd0, dout, dout_oe}, 16'd2);
            end
         endcase
      end

      // R7: unlock again; codes 01 and 10 then lock stays unchanged
      frame(2'b00, 6'b110000, 0, 16'h0, rd, dm); deselect();
      frame(2'b00, 6'b010000, 0, 16'h0, rd, dm); deselect();
      frame(2'b00, 6'b100000, 0, 16'h0, rd, dm); deselect();
      frame(2'b01, 6'd11, 16, 16'h3C3C, rd, dm);
      poll(s1, s2);
      check("R7 reserved ext codes keep unlock (busy)", {15'd0, s1}, 16'd0);
      frame(2'b10, 6'd11, 16, 16'h0, rd, dm); deselect();
      check("R7 write after reserved codes stored", rd, 16'h3C3C);

      // R11: abort a write after 8 data bits
      frame(2'b01, 6'd7, 8, 16'h0000, rd, dm);
      deselect();
      cs = 1'b1; waitc(8);
      check("R11 no busy after aborted write", {15'd0, dout}, 16'd1);
      deselect();
      frame(2'b10, 6'd7, 16, 16'h0, rd, dm); deselect();
      check("R11 aborted write leaves word", rd, 16'hFFFF);

      // R10: full write frame sent while programming is busy is dropped
      frame(2'b01, 6'd9, 16, 16'h0F0F, rd, dm);
      cs = 1'b0; waitc(4);
      frame(2'b01, 6'd10, 16, 16'h5555, rd, dm);
      deselect();
      waitc(BUSY + 40);
      frame(2'b10, 6'd10, 16, 16'h0, rd, dm); deselect();
      check("R10 frame during busy ignored", rd, 16'hFFFF);
      frame(2'b10, 6'd9, 16, 16'h0, rd, dm); deselect();
      check("R5 word written before busy frame", rd, 16'h0F0F);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule